// File: doc/BRIEF.md
# Double-Buffered Aligned PWM Channel Pair

This block holds two pulse-width modulation channels. Each one has its own counter, its own period and duty values, a polarity select, a choice of left-aligned (sawtooth) or center-aligned (triangle) counting, and an enable. Each counter advances only on cycles when the clock-enable source it has selected is high. The block takes four such enable strobes from an external prescaler. A period or duty write lands in a shadow register. The counter's working copy picks up the shadow value only at a period boundary, on an explicit counter clear, or while the channel is disabled. This lets software change the waveform without ever producing a truncated or doubled pulse.

Setting the concatenation input joins the two channels into one channel of twice the width. Channel 1 supplies the upper byte of the period and duty, and channel 0 supplies the lower byte. Channel 1's enable, mode, polarity and tick source control the joined channel, whose waveform appears on output 1. An emergency shutdown input forces both outputs to a chosen safe level for as long as it is held. The counters keep running underneath.

Top module: `pwm_pair`

## Requirements
- R1: While reset is asserted, and after reset until a channel is enabled (with polarity bits at 1), both bits of `pwm_o` are 0. All shadow and working registers clear to zero.
- R2: In left-aligned mode (`align_ctr_i[i]`=0), after a counter clear the position on the j-th selected tick is j mod PER. The output is in its active state while the position is below DUTY.
- R3: In center-aligned mode (`align_ctr_i[i]`=1), the counter runs up from 0 to PER and then back down, so one cycle lasts 2·PER ticks. The output is active while the position is below DUTY on the way up, and at or below DUTY on the way down.
- R4: `pol_i[i]`=1 makes the active state high. `pol_i[i]`=0 makes the active state low, and the idle state is always the opposite level.
- R5: DUTY=0 holds the output at its idle level for the whole period. DUTY≥PER holds it at its active level for the whole period.
- R6: A period or duty written while a channel runs does not change the current cycle. It takes effect from the first tick on which the counter returns to zero.
- R7: A pulse on `cnt_clr_i[i]` returns the count to zero and loads the shadow values at once.
- R8: A disabled channel holds its count at zero and drives its idle level. Its working copies follow the shadows every cycle. Enabling it without a clear starts counting at position 1 on the first tick.
- R9: With `concat_i`=1, one counter of width 2W uses period {per1,per0} and duty {duty1,duty0} with channel 1's controls, and drives `pwm_o[1]`. `pwm_o[0]` stays at channel 0's idle level.
- R10: Field `src_sel_i[2i+1:2i]` selects the bit of `src_tick_i` that advances channel i. The count does not move on cycles when that bit is low.
- R11: While `shdn_i` is 1, both outputs equal `safe_lvl_i` in the same cycle. The counters keep running, and normal output resumes at the current position when `shdn_i` drops.
- R12: The two channels count independently. Each one's waveform is unaffected by the other's mode or settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick_i | input | 4 | Four prescaled clock-enable strobes |
| ch_en_i | input | 2 | Per-channel enable |
| concat_i | input | 1 | Join both channels into one double-width channel |
| align_ctr_i | input | 2 | Per-channel mode: 1 center-aligned, 0 left-aligned |
| pol_i | input | 2 | Per-channel active level: 1 high, 0 low |
| src_sel_i | input | 4 | Two-bit tick source index per channel |
| per_we_i | input | 2 | Period shadow write strobe per channel |
| duty_we_i | input | 2 | Duty shadow write strobe per channel |
| cnt_clr_i | input | 2 | Counter clear and immediate load per channel |
| wdata_i | input | W | Write data for the shadow registers |
| shdn_i | input | 1 | Emergency shutdown |
| safe_lvl_i | input | 1 | Output level forced during shutdown |
| pwm_o | output | 2 | Channel outputs |

## Verification
The assertions assume that the mode, tick source and concatenation controls change only while the affected channel is disabled. Under that assumption a counter's step can be predicted from its own previous value. They also assume the polarity bit is steady across the cycle in which the idle level is checked. The stimulus keeps to these rules: every reconfiguration is done after clearing the enables and before the next enabling edge. Shadow writes are the only changes made while a channel runs, along with shutdown and clear pulses, which the properties allow at any time.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    TICK_P0 = 2'd0,
    TICK_P1 = 2'd1,
    TICK_P2 = 2'd2,
    TICK_P3 = 2'd3
  } tick_src_e;

  typedef struct packed {
    logic en;   // channel running
    logic ctr;  // center-aligned counting
    logic pol;  // active level
    logic clr;  // clear count and load shadows
  } chan_ctl_t;

endpackage

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel
  import pwm_pkg::*;
(
  input  logic [3:0] src_i,
  input  tick_src_e  sel_i,
  output logic       tick_o
);

  always_comb begin
    unique case (sel_i)
      TICK_P0: tick_o = src_i[0];
      TICK_P1: tick_o = src_i[1];
      TICK_P2: tick_o = src_i[2];
      TICK_P3: tick_o = src_i[3];
      default: tick_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  chan_ctl_t     ctl_i,
  input  logic [CW-1:0] per_sh_i,
  input  logic [CW-1:0] duty_sh_i,
  output logic [CW-1:0] cnt_o,
  output logic          load_o,
  output logic          out_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] per_q, per_d;
  logic [CW-1:0] duty_q, duty_d;
  logic          down_q, down_d;
  logic          out_q, out_d;
  logic          load;
  logic          active;

  // next-state
  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    per_d  = per_q;
    duty_d = duty_q;
    load   = 1'b0;
    if (!ctl_i.en) begin
      cnt_d  = '0;
      down_d = 1'b0;
      per_d  = per_sh_i;
      duty_d = duty_sh_i;
    end else if (ctl_i.clr) begin
      cnt_d  = '0;
      down_d = 1'b0;
      load   = 1'b1;
    end else if (tick_i) begin
      if (!ctl_i.ctr) begin
        if ((per_q == '0) || (cnt_q >= per_q - ONE)) begin
          cnt_d = '0;
          load  = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (!down_q) begin
        if (per_q == '0) begin
          cnt_d = '0;
          load  = 1'b1;
        end else if (cnt_q >= per_q - ONE) begin
          cnt_d  = per_q;
          down_d = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q <= ONE) begin
          cnt_d  = '0;
          down_d = 1'b0;
          load   = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
    if (load) begin
      per_d  = per_sh_i;
      duty_d = duty_sh_i;
    end
    active = (duty_d != '0) &&
             ((duty_d >= per_d) || (down_d ? (cnt_d <= duty_d) : (cnt_d < duty_d)));
    out_d  = ctl_i.en ? (active ? ctl_i.pol : ~ctl_i.pol) : ~ctl_i.pol;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      per_q  <= '0;
      duty_q <= '0;
      out_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      out_q  <= out_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = load;
  assign out_o  = out_q;

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   src_tick_i,
  input  logic [1:0]   ch_en_i,
  input  logic         concat_i,
  input  logic [1:0]   align_ctr_i,
  input  logic [1:0]   pol_i,
  input  logic [3:0]   src_sel_i,
  input  logic [1:0]   per_we_i,
  input  logic [1:0]   duty_we_i,
  input  logic [1:0]   cnt_clr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         shdn_i,
  input  logic         safe_lvl_i,
  output logic [1:0]   pwm_o
);

  localparam int NCH = 2;
  localparam int WW  = NCH * W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  // shadow registers
  logic [NCH-1:0][W-1:0] per_sh_q, per_sh_d;
  logic [NCH-1:0][W-1:0] duty_sh_q, duty_sh_d;

  always_comb begin
    per_sh_d  = per_sh_q;
    duty_sh_d = duty_sh_q;
    for (int i = 0; i < NCH; i++) begin
      if (per_we_i[i])  per_sh_d[i]  = wdata_i;
      if (duty_we_i[i]) duty_sh_d[i] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      per_sh_q  <= '0;
      duty_sh_q <= '0;
    end else begin
      per_sh_q  <= per_sh_d;
      duty_sh_q <= duty_sh_d;
    end
  end

  // narrow channels
  logic [NCH-1:0]        nar_en;
  logic [NCH-1:0]        nar_tick;
  logic [NCH-1:0]        nar_wrap;
  logic [NCH-1:0]        nar_out;
  logic [NCH-1:0][W-1:0] nar_cnt;
  chan_ctl_t [NCH-1:0]   nar_ctl;

  assign nar_en = ch_en_i & ~{NCH{concat_i}};

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      nar_ctl[i].en  = nar_en[i];
      nar_ctl[i].ctr = align_ctr_i[i];
      nar_ctl[i].pol = pol_i[i];
      nar_ctl[i].clr = cnt_clr_i[i];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_nar
    pwm_tick_sel u_sel (
      .src_i  (src_tick_i),
      .sel_i  (tick_src_e'(src_sel_i[2*g +: 2])),
      .tick_o (nar_tick[g])
    );

    pwm_core #(.CW(W)) u_core (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .tick_i    (nar_tick[g]),
      .ctl_i     (nar_ctl[g]),
      .per_sh_i  (per_sh_q[g]),
      .duty_sh_i (duty_sh_q[g]),
      .cnt_o     (nar_cnt[g]),
      .load_o    (nar_wrap[g]),
      .out_o     (nar_out[g])
    );
  end

  // joined double-width channel, controlled by channel 1
  logic          wd_en;
  logic          wd_wrap;
  logic          wd_out;
  logic [WW-1:0] wd_cnt;
  chan_ctl_t     wd_ctl;

  assign wd_en      = concat_i & ch_en_i[1];
  assign wd_ctl.en  = wd_en;
  assign wd_ctl.ctr = align_ctr_i[1];
  assign wd_ctl.pol = pol_i[1];
  assign wd_ctl.clr = |cnt_clr_i;

  pwm_core #(.CW(WW)) u_wide (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick_i    (nar_tick[1]),
    .ctl_i     (wd_ctl),
    .per_sh_i  ({per_sh_q[1], per_sh_q[0]}),
    .duty_sh_i ({duty_sh_q[1], duty_sh_q[0]}),
    .cnt_o     (wd_cnt),
    .load_o    (wd_wrap),
    .out_o     (wd_out)
  );

  // output select and shutdown override
  logic [NCH-1:0] pwm_raw;

  assign pwm_raw[0] = nar_out[0];
  assign pwm_raw[1] = concat_i ? wd_out : nar_out[1];
  assign pwm_o      = shdn_i ? {NCH{safe_lvl_i}} : pwm_raw;

endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk #(
  parameter int W = 8
) (
  input logic                clk,
  input logic                rst_core_n,
  input logic                shdn_i,
  input logic                safe_lvl_i,
  input logic [1:0]          pol_i,
  input logic                concat_i,
  input logic [1:0]          align_ctr_i,
  input logic [1:0]          cnt_clr_i,
  input logic [1:0]          pwm_o,
  input logic [1:0]          nar_en,
  input logic [1:0]          nar_tick,
  input logic [1:0]          nar_wrap,
  input logic [1:0][W-1:0]   nar_cnt,
  input logic                wd_en,
  input logic                wd_wrap,
  input logic [2*W-1:0]      wd_cnt
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) past_ok <= 1'b0;
    else             past_ok <= 1'b1;
  end

  AST_SHDN_FORCE: assert property (@(posedge clk) disable iff (!rst_core_n)
    shdn_i |-> (pwm_o == {2{safe_lvl_i}})); // R11

  for (genvar g = 0; g < 2; g++) begin : g_ch
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_core_n)
      (past_ok && !shdn_i && !$past(nar_en[g]) && $stable(pol_i[g]) &&
       ((g == 0) || (!concat_i && !$past(concat_i))))
      |-> (pwm_o[g] == !pol_i[g])); // R8

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
      !nar_en[g] |=> (nar_cnt[g] == '0)); // R8

    AST_LOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
      nar_wrap[g] |=> (nar_cnt[g] == '0)); // R6

    AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
      (nar_en[g] && nar_tick[g] && !nar_wrap[g] && !align_ctr_i[g])
      |=> (nar_cnt[g] == $past(nar_cnt[g]) + W'(1))); // R2

    AST_NO_TICK_FROZEN: assert property (@(posedge clk) disable iff (!rst_core_n)
      (nar_en[g] && !nar_tick[g] && !cnt_clr_i[g]) |=> $stable(nar_cnt[g])); // R10
  end

  AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !wd_en |=> (wd_cnt == '0)); // R9

  AST_WIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_core_n)
    wd_wrap |=> (wd_cnt == '0)); // R9

endmodule

bind pwm_pair pwm_pair_chk #(.W(W)) u_chk (.*);

// File: tb/pwm_pair_tb_top.sv
`timescale 1ns/1ps
module pwm_pair_tb_top;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [3:0]   src_tick_i;
  logic [1:0]   ch_en_i;
  logic         concat_i;
  logic [1:0]   align_ctr_i;
  logic [1:0]   pol_i;
  logic [3:0]   src_sel_i;
  logic [1:0]   per_we_i;
  logic [1:0]   duty_we_i;
  logic [1:0]   cnt_clr_i;
  logic [W-1:0] wdata_i;
  logic         shdn_i;
  logic         safe_lvl_i;
  logic [1:0]   pwm_o;

  int n_total = 0;
  int n_fail  = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  pwm_pair #(.W(W)) dut_i (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pwm_o=%b expected %b", tag, act, exp);
    end
  endtask

  // monitor: one expected item per cycle, sampled at the falling edge
  initial begin
    logic [1:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(pwm_o, e, t);
      end
    end
  end

  task automatic push(input logic [1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // level expected at position j after a clear (R2, R3, R4, R5)
  function automatic logic lvl(input bit ctr, input int per, input int duty,
                               input bit pol, input int j);
    int p;
    bit act;
    if (!ctr) begin
      p   = j % per;
      act = (duty != 0) && ((duty >= per) || (p < duty));
    end else begin
      p = j % (2 * per);
      if (p < per) act = (duty != 0) && ((duty >= per) || (p < duty));
      else         act = (duty != 0) && ((duty >= per) || ((2 * per - p) <= duty));
    end
    return act ? pol : !pol;
  endfunction

  task automatic wr(input bit is_duty, input int ch, input int val);
    @(posedge clk); #1;
    wdata_i = W'(val);
    if (is_duty) duty_we_i[ch] = 1'b1;
    else         per_we_i[ch]  = 1'b1;
    @(posedge clk); #1;
    per_we_i  = '0;
    duty_we_i = '0;
  endtask

  task automatic halt();
    @(posedge clk); #1;
    ch_en_i = '0;
  endtask

  // returns just after edge j=0, where the enable and clear take effect
  task automatic start_run(input logic [1:0] en_v, input logic [1:0] clr_v);
    @(posedge clk); #1;
    ch_en_i   = en_v;
    cnt_clr_i = clr_v;
    @(posedge clk); #1;
    cnt_clr_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_tick_i = 4'b1101; ch_en_i = '0; concat_i = 1'b0;
    align_ctr_i = '0; pol_i = 2'b11; src_sel_i = '0; per_we_i = '0;
    duty_we_i = '0; cnt_clr_i = '0; wdata_i = '0; shdn_i = 1'b0; safe_lvl_i = 1'b1;

    // R1 reset state
    repeat (3) @(posedge clk); #1;
    chk(pwm_o, 2'b00, "R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    chk(pwm_o, 2'b00, "R1 after reset");

    // R2 left-aligned
    wr(0, 0, 5); wr(1, 0, 2);
    start_run(2'b01, 2'b01);
    for (int j = 0; j < 20; j++) push({1'b0, lvl(0, 5, 2, 1, j)}, "R2 left-aligned");
    drain();

    // R4 inverted polarity
    halt(); pol_i[0] = 1'b0;
    start_run(2'b01, 2'b01);
    for (int j = 0; j < 20; j++) push({1'b0, lvl(0, 5, 2, 0, j)}, "R4 active low");
    drain();

    // R5 duty extremes
    halt(); pol_i[0] = 1'b1; wr(1, 0, 0);
    start_run(2'b01, 2'b01);
    for (int j = 0; j < 12; j++) push(2'b00, "R5 duty zero");
    drain();
    halt(); wr(1, 0, 9);
    start_run(2'b01, 2'b01);
    for (int j = 0; j < 12; j++) push(2'b01, "R5 duty above period");
    drain();

    // R3 center-aligned on ch1 with R12 ch0 left-aligned alongside
    halt(); wr(1, 0, 2); wr(0, 1, 4); wr(1, 1, 1); align_ctr_i = 2'b10;
    start_run(2'b11, 2'b11);
    for (int j = 0; j < 24; j++)
      push({lvl(1, 4, 1, 1, j), lvl(0, 5, 2, 1, j)}, "R3 R12 center and left");
    drain();

    // R11 shutdown during a run, counters continue
    halt();
    start_run(2'b11, 2'b11);
    for (int j = 0; j < 20; j++)
      if (j >= 3 && j < 8) push(2'b11, "R11 shutdown forced");
      else push({lvl(1, 4, 1, 1, j), lvl(0, 5, 2, 1, j)}, "R11 around shutdown");
    repeat (3) @(posedge clk); #1; shdn_i = 1'b1;
    repeat (5) @(posedge clk); #1; shdn_i = 1'b0;
    drain();

    // R6 writes during a run take effect at the wrap to zero
    halt(); align_ctr_i = 2'b00;
    start_run(2'b01, 2'b01);
    for (int j = 0; j < 22; j++)
      if (j < 10) push({1'b0, lvl(0, 5, 2, 1, j)}, "R6 old values kept");
      else push({1'b0, lvl(0, 3, 1, 1, j - 10)}, "R6 new values after wrap");
    repeat (6) @(posedge clk); #1; per_we_i[0] = 1'b1; wdata_i = 8'd3;
    @(posedge clk); #1; per_we_i = '0; duty_we_i[0] = 1'b1; wdata_i = 8'd1;
    @(posedge clk); #1; duty_we_i = '0;
    drain();

    // R7 clear loads shadows immediately
    halt(); wr(0, 0, 5); wr(1, 0, 2);
    start_run(2'b01, 2'b01);
    for (int j = 0; j < 14; j++)
      if (j < 3) push({1'b0, lvl(0, 5, 2, 1, j)}, "R7 before clear");
      else push({1'b0, lvl(0, 3, 1, 1, j - 3)}, "R7 after clear");
    per_we_i[0] = 1'b1; wdata_i = 8'd3;
    @(posedge clk); #1; per_we_i = '0; duty_we_i[0] = 1'b1; wdata_i = 8'd1;
    @(posedge clk); #1; duty_we_i = '0; cnt_clr_i = 2'b01;
    @(posedge clk); #1; cnt_clr_i = '0;
    drain();

    // R8 disabled channel idles and takes shadows; restart from position 1
    halt(); wr(0, 0, 5); wr(1, 0, 2);
    start_run(2'b01, 2'b01);
    for (int j = 0; j < 8; j++) push({1'b0, lvl(0, 5, 2, 1, j)}, "R8 before disable");
    drain();
    @(posedge clk); #1; ch_en_i = '0;
    @(posedge clk); #1;
    for (int j = 0; j < 6; j++) push(2'b00, "R8 disabled idle");
    per_we_i[0] = 1'b1; wdata_i = 8'd4;
    @(posedge clk); #1; per_we_i = '0; duty_we_i[0] = 1'b1; wdata_i = 8'd3;
    @(posedge clk); #1; duty_we_i = '0;
    drain();
    start_run(2'b01, 2'b00);
    for (int j = 0; j < 12; j++) push({1'b0, lvl(0, 4, 3, 1, j + 1)}, "R8 resume without clear");
    drain();

    // R9 joined 16-bit channel: period 0x0104, duty 0x0102
    halt(); concat_i = 1'b1;
    wr(0, 0, 8'h04); wr(0, 1, 8'h01); wr(1, 0, 8'h02); wr(1, 1, 8'h01);
    start_run(2'b10, 2'b10);
    for (int j = 0; j < 262; j++) push({lvl(0, 260, 258, 1, j), 1'b0}, "R9 joined channel");
    drain();

    // R10 tick source selection: source 1 idle, source 2 running
    halt(); concat_i = 1'b0; src_sel_i = 4'b0001; wr(0, 0, 5); wr(1, 0, 2);
    start_run(2'b01, 2'b01);
    for (int j = 0; j < 10; j++) push(2'b01, "R10 stalled source");
    drain();
    halt(); src_sel_i = 4'b0010;
    start_run(2'b01, 2'b01);
    for (int j = 0; j < 10; j++) push({1'b0, lvl(0, 5, 2, 1, j)}, "R10 running source");
    drain();

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule